// File: doc/BRIEF.md
# Local Interrupt Priority Selector

This block decides which local interrupt a hart should take next, if any. It looks at the per-source pending and enable bits, the delegation mask, the current privilege level and the two global interrupt-enable bits (machine and supervisor). From these it reports a valid flag and the cause number of the winning source. Trap entry, and interrupt routing for guests, stay outside the block. The three virtual-supervisor source positions are always excluded.

A source is a candidate when it is both pending and enabled. Sources not delegated are governed by the machine-level global enable. Delegated sources are governed by the supervisor-level global enable. Each global enable depends on the current privilege level. Among the qualifying sources, the one with the lowest index wins.

The result is either combinational or held in an output register. The register loads every cycle and clears on a synchronous reset. There is no flow control: the pins are plain status signals that track the inputs every cycle. No back-pressure applies.

Top module: `irq_select`

## Requirements
- R1: A source qualifies only if both its pending bit and its enable bit are 1. Source positions 2, 6 and 10 (the virtual-supervisor software, timer and external positions) are never selected, whatever their inputs.
- R2: The machine-level global enable is 1 when the privilege (2-bit code, user=0, supervisor=1, machine=3) is below 3, or when it equals 3 and the machine enable input is 1. Reserved code 2 therefore counts as below machine.
- R3: The supervisor-level global enable is 1 when the privilege is 0, or when it equals 1 and the supervisor enable input is 1. At privilege 2 or 3 it is 0, so delegated sources are never taken there.
- R4: A candidate whose delegation bit is 0 is taken only when the machine-level enable is 1. A candidate whose delegation bit is 1 is taken only when the supervisor-level enable is 1. The two gated sets are combined with OR.
- R5: When several sources qualify, the cause reported is the lowest qualifying bit index.
- R6: When no source qualifies, the valid output is 0 and the cause output is 0. When valid is 1, a cause of 0 means source 0.
- R7: With the output register enabled (REG_OUT=1, the default), outputs show the result for the inputs at the previous rising clock edge. A synchronous reset forces valid and cause to 0, whatever the inputs are.
- R8: With REG_OUT=0, outputs follow the inputs combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| pend_i | input | 16 | Pending bit per interrupt source |
| en_i | input | 16 | Enable bit per interrupt source |
| deleg_i | input | 16 | Delegation bit per source (1 = handled at supervisor level) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| irq_valid_o | output | 1 | A source was selected |
| irq_cause_o | output | 4 | Index of the selected source, 0 when none |

## Verification
The assertions assume that reset is held from time zero until after the first clock edge. They also assume that the inputs are stable around each rising edge, so that the checker's copy of the inputs matches what the output register captured. The bench drives every input on the falling edge and holds reset through the first edges.

Random stimulus uses all four privilege codes, including reserved code 2. Directed cases cover the masked positions, the delegation split, source 0 and the empty set.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_MACH  = 2'd3
  } priv_e;

  localparam int unsigned SRC_COUNT = 16;
  // software, timer, external positions of the guest supervisor level
  localparam logic [SRC_COUNT-1:0] GUEST_SRC_MASK = 16'h0444;
endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       m_gie_i,
  input  logic       s_gie_i,
  output logic       m_lvl_en_o,
  output logic       s_lvl_en_o
);
  localparam logic [1:0] MACH_CODE  = PRIV_MACH;
  localparam logic [1:0] SUPER_CODE = PRIV_SUPER;

  always_comb begin
    m_lvl_en_o = (priv_i < MACH_CODE) || ((priv_i == MACH_CODE) && m_gie_i);
    s_lvl_en_o = (priv_i < SUPER_CODE) || ((priv_i == SUPER_CODE) && s_gie_i);
  end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int unsigned            NUM_IRQ = 16,
  parameter logic [NUM_IRQ-1:0]     VS_MASK = '0
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic               m_lvl_en_i,
  input  logic               s_lvl_en_i,
  output logic [NUM_IRQ-1:0] qual_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    logic cand;
    logic lvl_ok;
    assign cand   = pend_i[i] & en_i[i] & ~VS_MASK[i];
    assign lvl_ok = deleg_i[i] ? s_lvl_en_i : m_lvl_en_i;
    assign qual_o[i] = cand & lvl_ok;
  end
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NUM_IRQ = 16,
  localparam int unsigned CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] req_i,
  output logic               any_o,
  output logic [CAUSE_W-1:0] idx_o
);
  logic [NUM_IRQ:0]   below;
  logic [NUM_IRQ-1:0] grant;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_chain
    assign grant[i]   = req_i[i] & ~below[i];
    assign below[i+1] = below[i] | req_i[i];
  end

  assign any_o = below[NUM_IRQ];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) idx_o = idx_o | CAUSE_W'(i);
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_sel_pkg::*;
#(
  parameter int unsigned        NUM_IRQ = SRC_COUNT,
  parameter logic [NUM_IRQ-1:0] VS_MASK = GUEST_SRC_MASK,
  parameter bit                 REG_OUT = 1'b1,
  localparam int unsigned       CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  output logic               irq_valid_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);
  logic               m_lvl_en, s_lvl_en;
  logic [NUM_IRQ-1:0] qual;
  logic               pick_any;
  logic [CAUSE_W-1:0] pick_idx;

  irq_level_gate u_gate (
    .priv_i     (priv_i),
    .m_gie_i    (m_gie_i),
    .s_gie_i    (s_gie_i),
    .m_lvl_en_o (m_lvl_en),
    .s_lvl_en_o (s_lvl_en)
  );

  irq_route #(.NUM_IRQ(NUM_IRQ), .VS_MASK(VS_MASK)) u_route (
    .pend_i     (pend_i),
    .en_i       (en_i),
    .deleg_i    (deleg_i),
    .m_lvl_en_i (m_lvl_en),
    .s_lvl_en_i (s_lvl_en),
    .qual_o     (qual)
  );

  irq_lowest_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .req_i (qual),
    .any_o (pick_any),
    .idx_o (pick_idx)
  );

  if (REG_OUT) begin : g_reg
    logic               valid_q;
    logic [CAUSE_W-1:0] cause_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        cause_q <= '0;
      end else begin
        valid_q <= pick_any;
        cause_q <= pick_idx;
      end
    end
    assign irq_valid_o = valid_q;
    assign irq_cause_o = cause_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk  = clk ^ rst;
    assign irq_valid_o = pick_any;
    assign irq_cause_o = pick_idx;
  end
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
  parameter int unsigned        NUM_IRQ = 16,
  parameter logic [NUM_IRQ-1:0] VS_MASK = '0,
  parameter bit                 REG_OUT = 1'b1,
  localparam int unsigned       CAUSE_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IRQ-1:0] pend_i,
  input logic [NUM_IRQ-1:0] en_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic               irq_valid_o,
  input logic [CAUSE_W-1:0] irq_cause_o
);
  logic [NUM_IRQ-1:0] s_pend, s_en, s_deleg;
  logic [1:0]         s_priv;
  logic               s_mgie, s_sgie;

  if (REG_OUT) begin : g_seen_reg
    always_ff @(posedge clk) begin
      s_pend  <= pend_i;
      s_en    <= en_i;
      s_deleg <= deleg_i;
      s_priv  <= priv_i;
      s_mgie  <= m_gie_i;
      s_sgie  <= s_gie_i;
    end
  end else begin : g_seen_comb
    assign s_pend  = pend_i;
    assign s_en    = en_i;
    assign s_deleg = deleg_i;
    assign s_priv  = priv_i;
    assign s_mgie  = m_gie_i;
    assign s_sgie  = s_gie_i;
  end

  logic [NUM_IRQ-1:0] lower_mask, same_side, lower_live;
  always_comb begin
    lower_mask = (NUM_IRQ'(1) << irq_cause_o) - NUM_IRQ'(1);
    same_side  = s_deleg[irq_cause_o] ? s_deleg : ~s_deleg;
    lower_live = s_pend & s_en & ~VS_MASK & same_side & lower_mask;
  end

  AST_SEL_PEND_EN: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (s_pend[irq_cause_o] && s_en[irq_cause_o])); // R1
  AST_NO_GUEST_SRC: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> !VS_MASK[irq_cause_o]); // R1
  AST_MACH_MASKED: assert property (@(posedge clk) disable iff (rst)
    (s_priv == 2'd3 && !s_mgie) |-> !irq_valid_o); // R2
  AST_DELEG_ABOVE_S: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && s_priv[1]) |-> !s_deleg[irq_cause_o]); // R3
  AST_DELEG_S_OFF: assert property (@(posedge clk) disable iff (rst)
    (irq_valid_o && s_priv == 2'd1 && !s_sgie) |-> !s_deleg[irq_cause_o]); // R4
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (lower_live == '0)); // R5
  AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> (irq_cause_o == '0)); // R6
endmodule

bind irq_select irq_select_chk #(
  .NUM_IRQ (NUM_IRQ),
  .VS_MASK (VS_MASK),
  .REG_OUT (REG_OUT)
) u_chk (.*);

// File: tb/irq_select_test.sv
`timescale 1ns/1ps
module irq_select_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]  priv = 2'd0;
  logic        mgie = 1'b0, sgie = 1'b0;
  logic        r_valid, c_valid;
  logic [3:0]  r_cause, c_cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_select uut (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie),
    .irq_valid_o(r_valid), .irq_cause_o(r_cause)
  );

  irq_select #(.REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie),
    .irq_valid_o(c_valid), .irq_cause_o(c_cause)
  );

  function automatic logic [4:0] expect_of(logic [15:0] p, logic [15:0] e,
      logic [15:0] d, logic [1:0] pr, logic mg, logic sg);
    logic [15:0] cand, q;
    logic men, sen;
    cand = p & e & ~16'h0444;
    men  = (pr != 2'd3) || mg;
    sen  = (pr == 2'd0) || (pr == 2'd1 && sg);
    q    = (cand & ~d & {16{men}}) | (cand & d & {16{sen}});
    for (int i = 0; i < 16; i++)
      if (q[i]) return {1'b1, 4'(i)};
    return 5'd0;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
               tag, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  logic [4:0] prev_exp = 5'd0;
  string      prev_tag = "R7";

  task automatic apply(logic [15:0] p, logic [15:0] e, logic [15:0] d,
      logic [1:0] pr, logic mg, logic sg, string tag);
    logic [4:0] ex;
    @(negedge clk);
    check({prev_tag, " R7 registered"}, {r_valid, r_cause}, prev_exp);
    pend = p; en = e; deleg = d; priv = pr; mgie = mg; sgie = sg;
    ex = expect_of(p, e, d, pr, mg, sg);
    #1;
    check({tag, " R8 comb"}, {c_valid, c_cause}, ex);
    prev_exp = ex;
    prev_tag = tag;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R7: reset clears the register even with live requests present
    @(negedge clk);
    pend = 16'hFFFF; en = 16'hFFFF; priv = 2'd0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R7 reset", {r_valid, r_cause}, 5'd0);
    pend = '0; en = '0;
    rst = 1'b0;
    prev_exp = 5'd0;

    apply(16'h0000, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, "R6 empty");
    apply(16'h0444, 16'hFFFF, 16'h0000, 2'd0, 1'b1, 1'b1, "R1 guest bits");
    apply(16'h0444, 16'hFFFF, 16'h0444, 2'd1, 1'b1, 1'b1, "R1 guest deleg");
    apply(16'h00F0, 16'h0F0F, 16'h0000, 2'd0, 1'b1, 1'b1, "R1 pend no en");
    apply(16'h0001, 16'h0001, 16'h0000, 2'd3, 1'b1, 1'b0, "R6 cause0");
    apply(16'h0880, 16'hFFFF, 16'h0000, 2'd3, 1'b0, 1'b1, "R2 mach off");
    apply(16'h0880, 16'hFFFF, 16'h0000, 2'd2, 1'b0, 1'b0, "R2 reserved");
    apply(16'h0220, 16'hFFFF, 16'h0220, 2'd3, 1'b1, 1'b1, "R3 deleg at M");
    apply(16'h0220, 16'hFFFF, 16'h0220, 2'd2, 1'b1, 1'b1, "R3 deleg reserved");
    apply(16'h0220, 16'hFFFF, 16'h0220, 2'd0, 1'b0, 1'b0, "R3 deleg at U");
    apply(16'h0A20, 16'hFFFF, 16'h0020, 2'd1, 1'b0, 1'b0, "R4 S split");
    apply(16'h0A20, 16'hFFFF, 16'h0020, 2'd1, 1'b0, 1'b1, "R4 S on");
    apply(16'h8008, 16'hFFFF, 16'h0008, 2'd3, 1'b1, 1'b0, "R4 M split");
    apply(16'hB090, 16'hFFFF, 16'h0000, 2'd0, 1'b0, 1'b0, "R5 many");
    apply(16'h8000, 16'h8000, 16'h0000, 2'd1, 1'b0, 1'b0, "R5 top");

    for (int n = 0; n < 400; n++) begin
      apply(16'($urandom), 16'($urandom), 16'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), "R5 random");
    end
    apply(16'h0000, 16'h0000, 16'h0000, 2'd0, 1'b0, 1'b0, "R6 drain");
    @(negedge clk);
    check({prev_tag, " R7 registered"}, {r_valid, r_cause}, prev_exp);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule